// File: doc/BRIEF.md
# Tape transport controller

This block is a synchronous Moore state machine that turns six front-panel button levels into six motor commands for a tape deck. The buttons are stop, pause, forward, rewind, play and record. At any time exactly one command is active: stop, pause, forward, rewind, play or record. Each command follows from the current state alone.

The machine never starts a running mode straight from idle. A press first moves it to an armed state for that mode, and the tape stays stopped there. The running mode begins on the first clock after the initiating button or buttons are released. Recording has to be armed by holding record and play together. In Play, the pause button toggles between Play and Pause on each new press. Holding pause down does not toggle it again.

When several buttons are high in the same cycle, a fixed priority picks one request before the state logic sees it. A request that the current state does not accept is then ignored. The next-state, arbitration and output-decode logic is combinational behind a 4-bit binary state register and a single pause-history flop.

Top module: `tape_xport_ctrl`

## Requirements
- R1: While rst_n is low, and on the first sample after it rises, drv_stop is 1 and the other five commands are 0.
- R2: Exactly one of the six command outputs is high in every cycle out of reset.
- R3: A high btn_stop returns the machine to idle (drv_stop only) on the next clock, from any state and whatever other buttons are high.
- R4: From idle, btn_forward moves to an armed state that drives drv_stop and stays there while btn_forward is held. On the first clock with btn_forward low it enters Forward, which drives drv_forward.
- R5: From idle, btn_rewind follows the same armed-then-run sequence and ends in Rewind, which drives drv_rewind.
- R6: From idle, btn_play alone arms playback (drv_stop) and, once btn_play is released, enters Play, which drives drv_play.
- R7: Recording is armed only when btn_record and btn_play are high in the same cycle. It runs (drv_record) on the first clock with both buttons low. btn_record with btn_play low has no effect.
- R8: In Play, a new pause press (btn_pause high after a cycle with it low) enters Pause, which drives drv_pause. Keeping pause held does not toggle again. The next new press returns to Play.
- R9: Simultaneous buttons resolve as stop, then record-with-play, then play, then forward, then rewind, then a new pause press. Only the winning request reaches the state logic.
- R10: In Forward, Rewind, Record, Play or Pause, the forward, rewind, play and record buttons have no effect.
- R11: A pause press in idle, in an armed state, or in Forward, Rewind or Record has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset to idle |
| btn_stop | input | 1 | Stop button level |
| btn_pause | input | 1 | Pause button level |
| btn_forward | input | 1 | Fast-forward button level |
| btn_rewind | input | 1 | Rewind button level |
| btn_play | input | 1 | Play button level |
| btn_record | input | 1 | Record button level |
| drv_stop | output | 1 | Tape-stopped command |
| drv_pause | output | 1 | Paused command |
| drv_forward | output | 1 | Fast-forward motor command |
| drv_rewind | output | 1 | Rewind motor command |
| drv_play | output | 1 | Playback command |
| drv_record | output | 1 | Record command |

## Verification
Two collisions are exercised. The first is button priority against state acceptance. When pause and play are pressed together in Play, play wins the arbitration and is then discarded by the running state, so the bench expects drv_play to remain. The second is an arming press against its own release. The bench holds play after record is dropped while armed for recording, and checks that the machine stays stopped until both buttons are low and only then drives drv_record. Several buttons are driven on one falling edge, and the command vector is judged one edge later against values taken from the priority rule.

// File: rtl/txc_pkg.sv
package txc_pkg;

   // Binary state code, 4 bits. Codes 10..15 are unused and recover to idle.
   typedef enum logic [3:0] {
      ST_IDLE     = 4'd0,
      ST_ARM_FWD  = 4'd1,
      ST_FWD      = 4'd2,
      ST_ARM_REW  = 4'd3,
      ST_REW      = 4'd4,
      ST_ARM_PLAY = 4'd5,
      ST_PLAY     = 4'd6,
      ST_ARM_REC  = 4'd7,
      ST_REC      = 4'd8,
      ST_PAUSED   = 4'd9
   } txc_state_e;

   localparam int unsigned STATE_W = $bits(txc_state_e);

   // Request slots. The lowest index has the highest priority.
   localparam int unsigned NUM_REQ   = 6;
   localparam int unsigned REQ_STOP  = 0;
   localparam int unsigned REQ_REC   = 1;
   localparam int unsigned REQ_PLAY  = 2;
   localparam int unsigned REQ_FWD   = 3;
   localparam int unsigned REQ_REW   = 4;
   localparam int unsigned REQ_PAUSE = 5;

   typedef struct packed {
      logic stop;
      logic pause;
      logic fwd;
      logic rew;
      logic play;
      logic rec;
   } txc_cmd_t;

   localparam int unsigned NUM_CMD = $bits(txc_cmd_t);

endpackage

// File: rtl/txc_prio_pick.sv
module txc_prio_pick #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   if (N < 2) begin : g_bad_width
      $error("txc_prio_pick: N must be at least 2");
   end

   // Grant goes to the lowest set index.
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/txc_next_state.sv
module txc_next_state
   import txc_pkg::*;
(
   input  txc_state_e           cur,
   input  logic [NUM_REQ-1:0]   gnt,
   input  logic                 btn_forward,
   input  logic                 btn_rewind,
   input  logic                 btn_play,
   input  logic                 btn_record,
   output txc_state_e           nxt
);

   always_comb begin
      nxt = cur;
      if (gnt[REQ_STOP]) begin
         nxt = ST_IDLE;
      end else begin
         case (cur)
            ST_IDLE: begin
               if      (gnt[REQ_REC])  nxt = ST_ARM_REC;
               else if (gnt[REQ_PLAY]) nxt = ST_ARM_PLAY;
               else if (gnt[REQ_FWD])  nxt = ST_ARM_FWD;
               else if (gnt[REQ_REW])  nxt = ST_ARM_REW;
               else                    nxt = ST_IDLE;
            end
            ST_ARM_FWD:  if (!btn_forward)              nxt = ST_FWD;
            ST_ARM_REW:  if (!btn_rewind)               nxt = ST_REW;
            ST_ARM_PLAY: if (!btn_play)                 nxt = ST_PLAY;
            ST_ARM_REC:  if (!btn_record && !btn_play)  nxt = ST_REC;
            ST_FWD, ST_REW, ST_REC: nxt = cur;
            ST_PLAY:     if (gnt[REQ_PAUSE])            nxt = ST_PAUSED;
            ST_PAUSED:   if (gnt[REQ_PAUSE])            nxt = ST_PLAY;
            default:     nxt = ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/txc_cmd_decode.sv
module txc_cmd_decode
   import txc_pkg::*;
(
   input  txc_state_e cur,
   output txc_cmd_t   cmd
);

   always_comb begin
      cmd = '0;
      case (cur)
         ST_FWD:    cmd.fwd   = 1'b1;
         ST_REW:    cmd.rew   = 1'b1;
         ST_PLAY:   cmd.play  = 1'b1;
         ST_REC:    cmd.rec   = 1'b1;
         ST_PAUSED: cmd.pause = 1'b1;
         default:   cmd.stop  = 1'b1;
      endcase
   end

endmodule

// File: rtl/tape_xport_ctrl.sv
module tape_xport_ctrl
   import txc_pkg::*;
#(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_stop,
   input  logic btn_pause,
   input  logic btn_forward,
   input  logic btn_rewind,
   input  logic btn_play,
   input  logic btn_record,
   output logic drv_stop,
   output logic drv_pause,
   output logic drv_forward,
   output logic drv_rewind,
   output logic drv_play,
   output logic drv_record
);

   if (STATE_W != 4) begin : g_bad_state_w
      $error("tape_xport_ctrl: state code must be 4 bits");
   end
   if (NUM_CMD != NUM_REQ) begin : g_bad_counts
      $error("tape_xport_ctrl: command and request counts differ");
   end

   txc_state_e         state_q;
   txc_state_e         state_d;
   logic               pause_q;
   logic               pause_rise;
   logic [NUM_REQ-1:0] req;
   logic [NUM_REQ-1:0] gnt;
   txc_cmd_t           cmd;

   assign pause_rise = btn_pause && !pause_q;

   always_comb begin
      req            = '0;
      req[REQ_STOP]  = btn_stop;
      req[REQ_REC]   = btn_record && btn_play;
      req[REQ_PLAY]  = btn_play;
      req[REQ_FWD]   = btn_forward;
      req[REQ_REW]   = btn_rewind;
      req[REQ_PAUSE] = pause_rise;
   end

   txc_prio_pick #(.N(NUM_REQ)) u_pick (
      .req (req),
      .gnt (gnt)
   );

   txc_next_state u_next (
      .cur         (state_q),
      .gnt         (gnt),
      .btn_forward (btn_forward),
      .btn_rewind  (btn_rewind),
      .btn_play    (btn_play),
      .btn_record  (btn_record),
      .nxt         (state_d)
   );

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state_q <= ST_IDLE;
            pause_q <= 1'b0;
         end else begin
            state_q <= state_d;
            pause_q <= btn_pause;
         end
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            state_q <= ST_IDLE;
            pause_q <= 1'b0;
         end else begin
            state_q <= state_d;
            pause_q <= btn_pause;
         end
      end
   end

   txc_cmd_decode u_dec (
      .cur (state_q),
      .cmd (cmd)
   );

   assign drv_stop    = cmd.stop;
   assign drv_pause   = cmd.pause;
   assign drv_forward = cmd.fwd;
   assign drv_rewind  = cmd.rew;
   assign drv_play    = cmd.play;
   assign drv_record  = cmd.rec;

endmodule

// File: rtl/txc_chk.sv
module txc_chk
   import txc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       btn_stop,
   input logic       btn_pause,
   input logic       btn_forward,
   input logic       btn_rewind,
   input logic       btn_play,
   input logic       btn_record,
   input logic       drv_stop,
   input logic       drv_pause,
   input logic       drv_forward,
   input logic       drv_rewind,
   input logic       drv_play,
   input logic       drv_record,
   input txc_state_e state_q
);

   logic [5:0] cmdv;
   assign cmdv = {drv_stop, drv_pause, drv_forward, drv_rewind, drv_play, drv_record};

   p_one_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(cmdv));

   p_stop_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
      btn_stop |=> (drv_stop && $countones(cmdv) == 1));

   p_arm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARM_FWD && btn_forward && !btn_stop) |=> state_q == ST_ARM_FWD);

   p_arm_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARM_FWD && !btn_forward && !btn_stop) |=> drv_forward);

   p_rew_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARM_REW && !btn_rewind && !btn_stop) |=> drv_rewind);

   p_lone_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && btn_record && !btn_play && !btn_forward && !btn_rewind)
      |=> state_q == ST_IDLE);

   p_pause_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_pause && !btn_stop && !btn_pause) |=> drv_pause);

   p_run_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((drv_forward || drv_rewind || drv_record) && !btn_stop) |=> $stable(cmdv));

   p_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      state_q <= ST_PAUSED);

endmodule

bind tape_xport_ctrl txc_chk u_txc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .btn_stop    (btn_stop),
   .btn_pause   (btn_pause),
   .btn_forward (btn_forward),
   .btn_rewind  (btn_rewind),
   .btn_play    (btn_play),
   .btn_record  (btn_record),
   .drv_stop    (drv_stop),
   .drv_pause   (drv_pause),
   .drv_forward (drv_forward),
   .drv_rewind  (drv_rewind),
   .drv_play    (drv_play),
   .drv_record  (drv_record),
   .state_q     (state_q)
);

// File: tb/tape_xport_ctrl_bench.sv
module tape_xport_ctrl_bench;

   localparam time CLK_PERIOD = 10ns;

   // Vector order for both buttons and commands: {stop,pause,fwd,rew,play,rec}
   localparam logic [5:0] K_STOP  = 6'b100000;
   localparam logic [5:0] K_PAUSE = 6'b010000;
   localparam logic [5:0] K_FWD   = 6'b001000;
   localparam logic [5:0] K_REW   = 6'b000100;
   localparam logic [5:0] K_PLAY  = 6'b000010;
   localparam logic [5:0] K_REC   = 6'b000001;
   localparam logic [5:0] K_NONE  = 6'b000000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] btn = '0;
   logic [5:0] cmd;
   int         checks = 0;
   int         errors = 0;

   logic drv_stop, drv_pause, drv_forward, drv_rewind, drv_play, drv_record;

   always #(CLK_PERIOD/2) clk = ~clk;

   tape_xport_ctrl u_tape_xport_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .btn_stop    (btn[5]),
      .btn_pause   (btn[4]),
      .btn_forward (btn[3]),
      .btn_rewind  (btn[2]),
      .btn_play    (btn[1]),
      .btn_record  (btn[0]),
      .drv_stop    (drv_stop),
      .drv_pause   (drv_pause),
      .drv_forward (drv_forward),
      .drv_rewind  (drv_rewind),
      .drv_play    (drv_play),
      .drv_record  (drv_record)
   );

   assign cmd = {drv_stop, drv_pause, drv_forward, drv_rewind, drv_play, drv_record};

   task automatic chk(input string tag, input logic [5:0] exp);
      checks++;
      if (cmd !== exp) begin
         errors++;
         $display("FAIL %s: cmd=%b expected %b", tag, cmd, exp);
      end
   endtask

   // Drive buttons at a falling edge, then wait through one rising edge.
   task automatic apply(input logic [5:0] b);
      btn = b;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      btn   = K_NONE;
      repeat (3) @(negedge clk);
      chk("R1 during reset", K_STOP);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", K_STOP);
   endtask

   task automatic t_forward;
      apply(K_FWD);           chk("R4 armed", K_STOP);
      apply(K_FWD);           chk("R4 armed while held", K_STOP);
      apply(K_NONE);          chk("R4 runs after release", K_FWD);
      apply(K_PLAY);          chk("R10 play ignored in forward", K_FWD);
      apply(K_REW);           chk("R10 rewind ignored in forward", K_FWD);
      apply(K_PAUSE);         chk("R11 pause ignored in forward", K_FWD);
      apply(K_STOP);          chk("R3 stop from forward", K_STOP);
      apply(K_NONE);
   endtask

   task automatic t_rewind;
      apply(K_REW);           chk("R5 armed", K_STOP);
      apply(K_NONE);          chk("R5 runs", K_REW);
      apply(K_STOP | K_FWD);  chk("R3 stop with forward", K_STOP);
      apply(K_NONE);          chk("R3 stays idle", K_STOP);
   endtask

   task automatic t_play_pause;
      apply(K_PLAY);          chk("R6 armed", K_STOP);
      apply(K_NONE);          chk("R6 runs", K_PLAY);
      apply(K_PAUSE);         chk("R8 enter pause", K_PAUSE);
      apply(K_PAUSE);         chk("R8 held pause no toggle", K_PAUSE);
      apply(K_NONE);          chk("R8 stays paused", K_PAUSE);
      apply(K_PLAY);          chk("R10 play ignored in pause", K_PAUSE);
      apply(K_NONE);
      apply(K_PAUSE);         chk("R8 second press resumes", K_PLAY);
      apply(K_NONE);
      apply(K_PAUSE | K_PLAY); chk("R9 play beats pause in play", K_PLAY);
      apply(K_NONE);
      apply(K_PAUSE);         chk("R9 later pause press works", K_PAUSE);
      apply(K_STOP);          chk("R3 stop from pause", K_STOP);
      apply(K_NONE);
   endtask

   task automatic t_record;
      apply(K_REC);           chk("R7 lone record", K_STOP);
      apply(K_NONE);          chk("R7 lone record not armed", K_STOP);
      apply(K_REC | K_PLAY);  chk("R7 armed", K_STOP);
      apply(K_PLAY);          chk("R7 waits for play release", K_STOP);
      apply(K_NONE);          chk("R7 runs", K_REC);
      apply(K_PAUSE);         chk("R11 pause ignored in record", K_REC);
      apply(K_FWD);           chk("R10 forward ignored in record", K_REC);
      apply(K_STOP);          chk("R3 stop from record", K_STOP);
      apply(K_NONE);
   endtask

   task automatic t_priority;
      apply(K_REC | K_PLAY | K_FWD | K_REW); chk("R9 all armed stopped", K_STOP);
      apply(K_NONE);          chk("R9 record wins", K_REC);
      apply(K_STOP);  apply(K_NONE);
      apply(K_PLAY | K_FWD | K_REW); apply(K_NONE);
      chk("R9 play wins", K_PLAY);
      apply(K_STOP);  apply(K_NONE);
      apply(K_FWD | K_REW);   apply(K_NONE);
      chk("R9 forward wins", K_FWD);
      apply(K_STOP);  apply(K_NONE);
      apply(K_STOP | K_REC | K_PLAY); apply(K_NONE);
      chk("R9 stop beats record", K_STOP);
   endtask

   task automatic t_pause_ignored;
      apply(K_PAUSE);         chk("R11 pause in idle", K_STOP);
      apply(K_NONE);          chk("R11 idle kept", K_STOP);
      apply(K_FWD);
      apply(K_FWD | K_PAUSE); chk("R11 pause in armed", K_STOP);
      apply(K_NONE);          chk("R11 armed still runs forward", K_FWD);
      apply(K_STOP);  apply(K_NONE);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_forward();
      t_rewind();
      t_play_pause();
      t_record();
      t_priority();
      t_pause_ignored();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule